// File: doc/BRIEF.md
# Access Attribute Region Resolver

This block gives every memory reference its effective access attributes. The attribute set has three parts: whether the reference is cacheable, whether operand writes are handled precisely, and whether the location is write-protected. Software programs two address windows and one default attribute set through a simple write port. Each window holds a base, a mask, an enable bit and an attribute set. Each reference carries an address, a source tag (processor core or debug unit) and a write flag.

The windows are checked in a fixed order. Window 0 is tested first. Window 1 is used only when window 0 does not match. A reference that matches neither window takes the default attributes. Only the upper `CMP_W` address bits take part in the match, and any bit whose mask bit is set is ignored. With the default `REG_OUT=1`, the result is registered and appears one clock after the request. The result reports which source supplied the attributes. A write that resolves to a write-protected attribute set raises a violation flag.

Top module: `attr_resolver`

## Requirements
- R1: After reset, both windows are disabled and the default attribute set is all zero, so every reference resolves to selector 0 with all attributes clear; `rsp_valid` is low out of reset.
- R2: A reference whose address matches enabled window 0 takes window 0's attributes, with `rsp_hit_sel` = 1. A window register write packs `cfg_wdata` as base [19:12], mask [11:4], enable [3], write-protect [2], precise [1], cacheable [0], with `cfg_sel` = 0 for window 0 and 1 for window 1.
- R3: Window 1 supplies the attributes (`rsp_hit_sel` = 2) only when window 0 does not match; when both match, window 0 wins.
- R4: When no window matches, the default attributes are returned with `rsp_hit_sel` = 0. The default is written with `cfg_sel` = 2, with attributes in `cfg_wdata[2:0]` in the same bit order as R2.
- R5: Address bits [31:24] are compared with the window base. A set mask bit excludes that address bit from the match. Address bits [23:0] never affect the match.
- R6: A window whose enable bit is clear never matches, whatever its base and mask.
- R7: References from the core (`req_src` = 0) and from the debug unit (`req_src` = 1) resolve identically, and `rsp_src` returns the request's tag.
- R8: `rsp_wp_fault` is high exactly when a valid write reference resolves to write-protected attributes. Reads never raise it.
- R9: `rsp_valid` and the resolved outputs appear one clock after the request is presented. Cycles without a request give `rsp_valid` low and all attribute outputs low.
- R10: A configuration write takes effect for a request presented in the very next cycle. A `cfg_sel` value of 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 window 0, 1 window 1, 2 default |
| cfg_wdata | input | 20 | Configuration write data |
| req_valid | input | 1 | Reference present |
| req_addr | input | 32 | Reference address |
| req_src | input | 1 | Source tag: 0 core, 1 debug |
| req_write | input | 1 | Reference is a write |
| rsp_valid | output | 1 | Result valid |
| rsp_cacheable | output | 1 | Resolved cacheable attribute |
| rsp_precise | output | 1 | Resolved precise-write attribute |
| rsp_wprot | output | 1 | Resolved write-protect attribute |
| rsp_hit_sel | output | 2 | Attribute source: 0 default, 1 window 0, 2 window 1 |
| rsp_src | output | 1 | Returned source tag |
| rsp_wp_fault | output | 1 | Write to a write-protected location |

## Verification
A corrupted base, mask or enable register does not stay hidden. It shows up on the first reference whose upper byte lands on the damaged bit, one clock later, as a wrong `rsp_hit_sel` and usually wrong attributes. A fault in the priority chain shows only when both windows match at once, so the stimulus deliberately aims addresses at overlapping windows. A wrong default register shows on any reference that misses both windows. The write-protect flag is cross-checked against the request's write bit on every response cycle.

// File: rtl/attr_pkg.sv
package attr_pkg;

   // Attribute bit order within the packed word: [2] wprot, [1] precise, [0] cacheable
   typedef struct packed {
      logic wprot;
      logic precise;
      logic cacheable;
   } attr_t;

   localparam int ATTR_W = $bits(attr_t);

   // Position of the enable bit and field base offsets inside a window word
   localparam int CFG_EN_BIT   = ATTR_W;
   localparam int CFG_MASK_LSB = ATTR_W + 1;

endpackage

// File: rtl/attr_cfg_regs.sv
module attr_cfg_regs
   import attr_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int CMP_W   = 8,
   parameter int SEL_W   = 2,
   parameter int CFG_W   = 2 * CMP_W + ATTR_W + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [SEL_W-1:0]               cfg_sel,
   input  logic [CFG_W-1:0]               cfg_wdata,
   output logic [NUM_WIN-1:0][CMP_W-1:0]  win_base,
   output logic [NUM_WIN-1:0][CMP_W-1:0]  win_mask,
   output logic [NUM_WIN-1:0]             win_en,
   output attr_t [NUM_WIN-1:0]            win_attr,
   output attr_t                          def_attr
);

   localparam int BASE_LSB = CFG_MASK_LSB + CMP_W;

   if (CFG_W != BASE_LSB + CMP_W) begin : g_bad_cfg_w
      $error("attr_cfg_regs: CFG_W does not match the window word layout");
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      logic wr_hit;
      assign wr_hit = cfg_we && (cfg_sel == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_base[g] <= '0;
            win_mask[g] <= '0;
            win_en[g]   <= 1'b0;
            win_attr[g] <= '0;
         end else if (wr_hit) begin
            win_base[g] <= cfg_wdata[BASE_LSB +: CMP_W];
            win_mask[g] <= cfg_wdata[CFG_MASK_LSB +: CMP_W];
            win_en[g]   <= cfg_wdata[CFG_EN_BIT];
            win_attr[g] <= attr_t'(cfg_wdata[ATTR_W-1:0]);
         end
      end
   end

   logic def_wr;
   assign def_wr = cfg_we && (cfg_sel == SEL_W'(NUM_WIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         def_attr <= '0;
      end else if (def_wr) begin
         def_attr <= attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
   end

endmodule

// File: rtl/attr_win_match.sv
module attr_win_match #(
   parameter int CMP_W = 8
) (
   input  logic [CMP_W-1:0] addr_hi,
   input  logic [CMP_W-1:0] base,
   input  logic [CMP_W-1:0] mask,
   input  logic             en,
   output logic             hit
);

   logic [CMP_W-1:0] diff;

   always_comb begin
      diff = (addr_hi ^ base) & ~mask;
      hit  = en && (diff == '0);
   end

endmodule

// File: rtl/attr_prio_sel.sv
module attr_prio_sel
   import attr_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int SEL_W   = 2
) (
   input  logic [NUM_WIN-1:0]  win_hit,
   input  attr_t [NUM_WIN-1:0] win_attr,
   input  attr_t               def_attr,
   output attr_t               res_attr,
   output logic [SEL_W-1:0]    res_sel
);

   // Scan from the highest window down so the lowest index wins last
   always_comb begin
      res_attr = def_attr;
      res_sel  = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (win_hit[i]) begin
            res_attr = win_attr[i];
            res_sel  = SEL_W'(i + 1);
         end
      end
   end

endmodule

// File: rtl/attr_resolver.sv
module attr_resolver
   import attr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CMP_W   = 8,
   parameter int NUM_WIN = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [$clog2(NUM_WIN+1)-1:0]   cfg_sel,
   input  logic [2*CMP_W+ATTR_W:0]        cfg_wdata,
   input  logic                           req_valid,
   input  logic [ADDR_W-1:0]              req_addr,
   input  logic                           req_src,
   input  logic                           req_write,
   output logic                           rsp_valid,
   output logic                           rsp_cacheable,
   output logic                           rsp_precise,
   output logic                           rsp_wprot,
   output logic [$clog2(NUM_WIN+1)-1:0]   rsp_hit_sel,
   output logic                           rsp_src,
   output logic                           rsp_wp_fault
);

   localparam int SEL_W = $clog2(NUM_WIN + 1);
   localparam int CFG_W = 2 * CMP_W + ATTR_W + 1;
   localparam int LO_W  = ADDR_W - CMP_W;

   if (NUM_WIN < 1 || NUM_WIN > 6) begin : g_bad_num_win
      $error("attr_resolver: NUM_WIN must be between 1 and 6");
   end
   if (CMP_W < 1 || CMP_W >= ADDR_W) begin : g_bad_cmp_w
      $error("attr_resolver: CMP_W must be at least 1 and below ADDR_W");
   end

   logic [NUM_WIN-1:0][CMP_W-1:0] win_base;
   logic [NUM_WIN-1:0][CMP_W-1:0] win_mask;
   logic [NUM_WIN-1:0]            win_en;
   attr_t [NUM_WIN-1:0]           win_attr;
   attr_t                         def_attr;
   logic [NUM_WIN-1:0]            win_hit;
   attr_t                         res_attr;
   logic [SEL_W-1:0]              res_sel;
   logic [CMP_W-1:0]              addr_hi;
   logic [LO_W-1:0]               lo_addr_unused;
   logic                          res_fault;

   assign addr_hi        = req_addr[ADDR_W-1 -: CMP_W];
   assign lo_addr_unused = req_addr[LO_W-1:0];

   attr_cfg_regs #(
      .NUM_WIN (NUM_WIN),
      .CMP_W   (CMP_W),
      .SEL_W   (SEL_W),
      .CFG_W   (CFG_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .win_base  (win_base),
      .win_mask  (win_mask),
      .win_en    (win_en),
      .win_attr  (win_attr),
      .def_attr  (def_attr)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
      attr_win_match #(
         .CMP_W (CMP_W)
      ) u_match (
         .addr_hi (addr_hi),
         .base    (win_base[g]),
         .mask    (win_mask[g]),
         .en      (win_en[g]),
         .hit     (win_hit[g])
      );
   end

   attr_prio_sel #(
      .NUM_WIN (NUM_WIN),
      .SEL_W   (SEL_W)
   ) u_prio (
      .win_hit  (win_hit),
      .win_attr (win_attr),
      .def_attr (def_attr),
      .res_attr (res_attr),
      .res_sel  (res_sel)
   );

   assign res_fault = req_valid && req_write && res_attr.wprot;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_cacheable <= 1'b0;
            rsp_precise   <= 1'b0;
            rsp_wprot     <= 1'b0;
            rsp_hit_sel   <= '0;
            rsp_src       <= 1'b0;
            rsp_wp_fault  <= 1'b0;
         end else begin
            rsp_valid     <= req_valid;
            rsp_cacheable <= req_valid && res_attr.cacheable;
            rsp_precise   <= req_valid && res_attr.precise;
            rsp_wprot     <= req_valid && res_attr.wprot;
            rsp_hit_sel   <= req_valid ? res_sel : '0;
            rsp_src       <= req_valid && req_src;
            rsp_wp_fault  <= res_fault;
         end
      end
   end else begin : g_comb_out
      always_comb begin
         rsp_valid     = req_valid;
         rsp_cacheable = req_valid && res_attr.cacheable;
         rsp_precise   = req_valid && res_attr.precise;
         rsp_wprot     = req_valid && res_attr.wprot;
         rsp_hit_sel   = req_valid ? res_sel : '0;
         rsp_src       = req_valid && req_src;
         rsp_wp_fault  = res_fault;
      end
   end

endmodule

// File: rtl/attr_resolver_chk.sv
module attr_resolver_chk #(
   parameter int NUM_WIN = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic                         req_src,
   input logic                         req_write,
   input logic [NUM_WIN-1:0]           win_hit,
   input logic [NUM_WIN-1:0]           win_en,
   input logic                         rsp_valid,
   input logic [$clog2(NUM_WIN+1)-1:0] rsp_hit_sel,
   input logic                         rsp_src,
   input logic                         rsp_wprot,
   input logic                         rsp_wp_fault
);

   localparam int SEL_W = $clog2(NUM_WIN + 1);

   AST_FAULT_NEEDS_WPROT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_wp_fault |-> (rsp_valid && rsp_wprot)); // R8

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit_sel <= SEL_W'(NUM_WIN))); // R4

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
      AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         !win_en[g] |-> !win_hit[g]); // R6
   end

   if (REG_OUT) begin : g_reg
      AST_VALID_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid); // R9
      AST_IDLE_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!rsp_valid && !rsp_wprot)); // R9
      AST_WIN0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && win_hit[0]) |=> (rsp_hit_sel == SEL_W'(1))); // R2
      AST_SRC_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> (rsp_src == $past(req_src))); // R7
      AST_NO_FAULT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_write) |=> !rsp_wp_fault); // R8
      if (NUM_WIN >= 2) begin : g_two
         AST_WIN1_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !win_hit[0] && win_hit[1]) |=> (rsp_hit_sel == SEL_W'(2))); // R3
      end
   end else begin : g_comb
      AST_VALID_SAME: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |-> rsp_valid); // R9
      AST_WIN0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && win_hit[0]) |-> (rsp_hit_sel == SEL_W'(1))); // R2
      AST_SRC_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |-> (rsp_src == req_src)); // R7
      AST_NO_FAULT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_write) |-> !rsp_wp_fault); // R8
   end

endmodule

bind attr_resolver attr_resolver_chk #(
   .NUM_WIN (NUM_WIN),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_src      (req_src),
   .req_write    (req_write),
   .win_hit      (win_hit),
   .win_en       (win_en),
   .rsp_valid    (rsp_valid),
   .rsp_hit_sel  (rsp_hit_sel),
   .rsp_src      (rsp_src),
   .rsp_wprot    (rsp_wprot),
   .rsp_wp_fault (rsp_wp_fault)
);

// File: tb/test_attr_resolver.sv
`timescale 1ns/1ps
module test_attr_resolver;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [19:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_src = 1'b0;
   logic        req_write = 1'b0;
   logic        rsp_valid, rsp_cacheable, rsp_precise, rsp_wprot, rsp_src, rsp_wp_fault;
   logic [1:0]  rsp_hit_sel;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] m_base [2];
   logic [7:0] m_mask [2];
   logic       m_en   [2];
   logic [2:0] m_attr [2];
   logic [2:0] m_def;

   always #10 clk = ~clk;

   attr_resolver i_attr_resolver (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_addr(req_addr), .req_src(req_src), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable), .rsp_precise(rsp_precise),
      .rsp_wprot(rsp_wprot), .rsp_hit_sel(rsp_hit_sel), .rsp_src(rsp_src),
      .rsp_wp_fault(rsp_wp_fault)
   );

   function automatic logic [4:0] model(input logic [31:0] a);
      logic [7:0] t;
      t = a[31:24];
      if (m_en[0] && (((t ^ m_base[0]) & ~m_mask[0]) == 8'h00)) return {2'd1, m_attr[0]};
      if (m_en[1] && (((t ^ m_base[1]) & ~m_mask[1]) == 8'h00)) return {2'd2, m_attr[1]};
      return {2'd0, m_def};
   endfunction

   task automatic cfg_write(input logic [1:0] sel, input logic [7:0] base,
                            input logic [7:0] mask, input logic en, input logic [2:0] attr);
      cfg_we    = 1'b1;
      cfg_sel   = sel;
      cfg_wdata = {base, mask, en, attr};
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel < 2'd2) begin
         m_base[sel] = base; m_mask[sel] = mask; m_en[sel] = en; m_attr[sel] = attr;
      end else if (sel == 2'd2) begin
         m_def = attr;
      end
   endtask

   // Drive at a falling edge, result registered at the next rising edge, sampled at the falling edge after
   task automatic check_req(input logic [31:0] a, input logic src, input logic wr, input string tag);
      logic [4:0] e;
      logic [7:0] exp_v, act_v;
      e = model(a);
      req_valid = 1'b1; req_addr = a; req_src = src; req_write = wr;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      exp_v = {1'b1, e[4:3], e[2], e[1], e[0], src, wr & e[2]};
      act_v = {rsp_valid, rsp_hit_sel, rsp_wprot, rsp_precise, rsp_cacheable, rsp_src, rsp_wp_fault};
      n_checks++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%b expected=%b", tag, a, act_v, exp_v);
      end
   endtask

   task automatic check_idle(input string tag);
      logic [7:0] act_v;
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      act_v = {rsp_valid, rsp_hit_sel, rsp_wprot, rsp_precise, rsp_cacheable, rsp_src, rsp_wp_fault};
      n_checks++;
      if (act_v !== 8'h00) begin
         n_fail++;
         $display("FAIL %s idle actual=%b expected=%b", tag, act_v, 8'h00);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 2; i++) begin
         m_base[i] = '0; m_mask[i] = '0; m_en[i] = 1'b0; m_attr[i] = '0;
      end
      m_def = '0;
      repeat (3) @(negedge clk);
      n_checks++;
      if (rsp_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 rsp_valid in reset actual=%b expected=0", rsp_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check_req(32'hA5000000, 1'b0, 1'b1, "R1");
      check_idle("R9");

      cfg_write(2'd2, 8'h00, 8'h00, 1'b0, 3'b011);
      check_req(32'h12345678, 1'b0, 1'b0, "R4 R10");
      cfg_write(2'd0, 8'h40, 8'h00, 1'b1, 3'b101);
      check_req(32'h40123456, 1'b0, 1'b0, "R2");
      check_req(32'h41000000, 1'b0, 1'b0, "R4");
      check_req(32'h40FFFFFF, 1'b0, 1'b0, "R5");
      cfg_write(2'd1, 8'h40, 8'h0F, 1'b1, 3'b010);
      check_req(32'h40000000, 1'b0, 1'b0, "R3");
      check_req(32'h4F000001, 1'b0, 1'b0, "R3 R5");
      check_req(32'h50000000, 1'b0, 1'b0, "R5");
      check_req(32'h4F000001, 1'b1, 1'b0, "R7");
      check_req(32'h40000000, 1'b1, 1'b1, "R8");
      cfg_write(2'd0, 8'h40, 8'h00, 1'b0, 3'b101);
      check_req(32'h40000000, 1'b0, 1'b0, "R6");
      cfg_write(2'd1, 8'h40, 8'hFF, 1'b0, 3'b111);
      check_req(32'h40000000, 1'b0, 1'b1, "R6");
      cfg_write(2'd0, 8'hC0, 8'h00, 1'b1, 3'b100);
      check_req(32'hC0000000, 1'b0, 1'b1, "R8");
      check_req(32'hC0000000, 1'b0, 1'b0, "R8");
      cfg_write(2'd3, 8'h00, 8'h00, 1'b1, 3'b111);
      check_req(32'h77000000, 1'b0, 1'b0, "R10");
      check_req(32'hC0000000, 1'b1, 1'b0, "R10");
      check_idle("R9");

      for (int n = 0; n < 1500; n++) begin
         logic [31:0] a;
         logic [1:0]  pick;
         if ($urandom % 6 == 0) begin
            logic [1:0] s;
            logic [7:0] mk;
            s  = 2'($urandom % 3);
            mk = ($urandom % 2) ? 8'($urandom) & 8'($urandom) : 8'h00;
            cfg_write(s, 8'($urandom), mk, 1'($urandom % 4 != 0), 3'($urandom));
         end
         pick = 2'($urandom % 3);
         a = $urandom;
         if (pick == 2'd0) a[31:24] = m_base[0] ^ (8'($urandom) & m_mask[0]);
         if (pick == 2'd1) a[31:24] = m_base[1] ^ (8'($urandom) & m_mask[1]);
         if ($urandom % 10 == 0) check_idle("R9");
         else check_req(a, 1'($urandom), 1'($urandom), "R2 R3 R4 R5 R6 R7 R8");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule